// File: doc/BRIEF.md
# I3C Controller Command Intake

This block is the command-side front end of an I3C bus controller. Software writes 32-bit words into a single command port. An argument word is held until the command word that follows it arrives. The block then stores the pair in a small command queue. The queue head is decoded into a transfer descriptor, which is offered to the bus engine over a valid/ready handshake. One transfer runs at a time. When the engine reports completion, the block can push a 32-bit response word into a response FIFO, which software drains through a read port.

Register access is a flat word-addressed bus. A read returns data in the same cycle it is requested (combinational `csr_rdata`). The word addresses are:

- 0: control
- 1: command port
- 2: response port
- 3: queue status
- 4: data status

The descriptor handshake follows the usual stream rules. While `xfer_valid` is high and `xfer_ready` is low, the descriptor does not change. The entry is consumed on the cycle where both are high. A completion pulse on `done_valid` is only honoured while a transfer is in flight. There is no back-pressure on completion: the block never issues a transfer unless the response FIFO has room for its response.

Top module: `i3c_cmdq_front`

## Requirements
- R1: Bits 2:0 of a command-port word select its kind: 0 is a transfer command, 1 is a transfer argument and 2 is a short-data argument. A word with code 3 to 7 changes nothing, including any argument already held.
- R2: An argument word is held until the next command word, and the two are queued as one entry. A command with no held argument uses an all-zero argument. A later argument replaces an earlier one that has not yet been used.
- R3: From the command word, the descriptor carries these fields:
  - TID from bits 6:3
  - CCC code from bits 14:7
  - CCC-present flag from bit 15
  - device index from bits 20:16
  - speed from bits 23:21
  - short-data flag from bit 27
  - read flag from bit 28
  - terminate flag from bit 30
  - PEC flag from bit 31
- R4: `xfer_arg_bytes` is argument bits 31:8; for a transfer argument, the defining byte is bits 15:8. `xfer_len` depends on command bit 27:
  - bit 27 clear: `xfer_len` is argument bits 31:16.
  - bit 27 set: `xfer_len` is the number of ones in argument bits 5:3, the byte strobes.
- R5: Transfers are issued only while the enable bit (control bit 31) is set. Commands written while it is clear stay queued. Control bit 31 reads back as written, and bit 30 always reads 0.
- R6: Entries are issued in write order with at most one in flight. The descriptor is held steady until it is accepted. No new descriptor is offered until `done_valid` ends the current transfer.
- R7: A completion pushes a response only if command bit 26 (response-on-completion) was set. The response word is laid out as:
  - bits 15:0: `done_len`
  - bits 23:16: the CCC code if bit 15 was set, otherwise 0
  - bits 27:24: the TID
  - bits 31:28: `done_err`

  A `done_valid` pulse while no transfer is in flight has no effect.
- R8: A completion with nonzero `done_err` stops further issue until a control write with bit 30 (resume) set.
- R9: The queue status word holds the free command entries in bits 7:0 and the response FIFO fill level in bits 15:8. Reading the response port pops the oldest response, in push order. Reading it while empty returns 0.
- R10: A command written while the command queue is full is dropped, together with its argument.
- R11: No transfer is issued while the response FIFO is full. Issue resumes once a response is read.
- R12: The data status word holds `tx_free` in bits 7:0 and `rx_level` in bits 23:16, with other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe (pops the response port) |
| csr_addr | input | 3 | Register word address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, same cycle |
| tx_free | input | 8 | Free TX data locations |
| rx_level | input | 8 | RX data fill level in words |
| xfer_valid | output | 1 | Descriptor offered to the bus engine |
| xfer_ready | input | 1 | Bus engine accepts the descriptor |
| xfer_tid | output | 4 | Transaction ID |
| xfer_ccc | output | 8 | CCC code |
| xfer_ccc_en | output | 1 | CCC present |
| xfer_dev | output | 5 | Device index |
| xfer_speed | output | 3 | Speed mode |
| xfer_rnw | output | 1 | Read (1) or write (0) |
| xfer_short | output | 1 | Short-data argument in use |
| xfer_toc | output | 1 | Terminate on completion |
| xfer_pec | output | 1 | PEC enabled |
| xfer_len | output | 16 | Byte count |
| xfer_arg_bytes | output | 24 | Argument bits 31:8 (defining byte or short data) |
| done_valid | input | 1 | Transfer completion pulse |
| done_len | input | 16 | Completed data length |
| done_err | input | 4 | Completion error status, 0 is success |

## Verification
Some internal faults show up as a wrong descriptor field on `xfer_*` the first cycle the entry reaches the queue head:
- a stale argument register
- a skipped pairing clear

Faults in the in-flight tracking show on the ports within one or two cycles of a handshake or completion:
- a lost busy flag shows as a second `xfer_valid` before `done_valid`
- a wrong latched TID shows as a wrong response word
- a lost halt shows as `xfer_valid` returning before resume

Queue occupancy errors surface in the queue status word right after the offending write, or as a missing or extra descriptor once issue is enabled.

// File: rtl/i3c_cmdq_pkg.sv
package i3c_cmdq_pkg;
  // command-port word kinds (bits 2:0)
  localparam logic [2:0] ATTR_CMD   = 3'd0;
  localparam logic [2:0] ATTR_ARG   = 3'd1;
  localparam logic [2:0] ATTR_SHORT = 3'd2;

  // register word addresses
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_CMDP  = 3'd1;
  localparam logic [2:0] REG_RESP  = 3'd2;
  localparam logic [2:0] REG_QSTAT = 3'd3;
  localparam logic [2:0] REG_DSTAT = 3'd4;

  typedef struct packed {
    logic [31:0] arg;
    logic [31:0] cmd;
  } cmdq_entry_t;
endpackage

// File: rtl/i3c_cmdq_fifo.sv
module i3c_cmdq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  // a push into a full FIFO is dropped
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/i3c_cmdq_pair.sv
module i3c_cmdq_pair
  import i3c_cmdq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        push,
  output cmdq_entry_t entry
);
  logic [31:0] arg_q;
  logic        arg_v;
  logic [2:0]  attr;

  assign attr = wdata[2:0];

  always_comb begin
    push      = wr && (attr == ATTR_CMD);
    entry.cmd = wdata;
    entry.arg = arg_v ? arg_q : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q <= '0;
      arg_v <= 1'b0;
    end else if (wr) begin
      if (attr == ATTR_ARG || attr == ATTR_SHORT) begin
        arg_q <= wdata;
        arg_v <= 1'b1;
      end else if (attr == ATTR_CMD) begin
        arg_v <= 1'b0;
      end
    end
  end

  p_arg_used_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !arg_v);
  p_unknown_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && attr > ATTR_SHORT) |=> ($stable(arg_v) && $stable(arg_q)));
endmodule

// File: rtl/i3c_cmdq_front.sv
module i3c_cmdq_front
  import i3c_cmdq_pkg::*;
#(
  parameter int CMD_DEPTH  = 4,
  parameter int RESP_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic        csr_re,
  input  logic [2:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic [7:0]  tx_free,
  input  logic [7:0]  rx_level,
  output logic        xfer_valid,
  input  logic        xfer_ready,
  output logic [3:0]  xfer_tid,
  output logic [7:0]  xfer_ccc,
  output logic        xfer_ccc_en,
  output logic [4:0]  xfer_dev,
  output logic [2:0]  xfer_speed,
  output logic        xfer_rnw,
  output logic        xfer_short,
  output logic        xfer_toc,
  output logic        xfer_pec,
  output logic [15:0] xfer_len,
  output logic [23:0] xfer_arg_bytes,
  input  logic        done_valid,
  input  logic [15:0] done_len,
  input  logic [3:0]  done_err
);
  localparam int CCW = $clog2(CMD_DEPTH + 1);
  localparam int RCW = $clog2(RESP_DEPTH + 1);
  localparam logic [CCW-1:0] CDEP = CCW'(CMD_DEPTH);

  logic            en_q, halted, busy;
  logic            fl_roc;
  logic [3:0]      fl_tid;
  logic [7:0]      fl_ccc;

  logic            ctrl_wr, cmd_wr, resume;
  logic            pr_push;
  cmdq_entry_t     pr_entry, head;
  logic            cq_full, cq_empty, cq_pop;
  logic [CCW-1:0]  cq_count, cq_free;
  logic            rq_push, rq_pop, rq_full, rq_empty;
  logic [31:0]     rq_din, rq_dout;
  logic [RCW-1:0]  rq_count;
  logic            fire, finish;
  logic            unused_bits;

  assign ctrl_wr = csr_we && (csr_addr == REG_CTRL);
  assign cmd_wr  = csr_we && (csr_addr == REG_CMDP);
  assign resume  = ctrl_wr && csr_wdata[30];

  i3c_cmdq_pair u_pair (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cmd_wr),
    .wdata (csr_wdata),
    .push  (pr_push),
    .entry (pr_entry)
  );

  i3c_cmdq_fifo #(.W($bits(cmdq_entry_t)), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (pr_push),
    .din   (pr_entry),
    .pop   (cq_pop),
    .dout  (head),
    .full  (cq_full),
    .empty (cq_empty),
    .count (cq_count)
  );

  // issue gate: enabled, not halted, idle, work queued, room for a response
  assign xfer_valid = en_q && !halted && !busy && !cq_empty && !rq_full;
  assign fire       = xfer_valid && xfer_ready;
  assign cq_pop     = fire;
  assign finish     = done_valid && busy;

  // descriptor decode of the queue head
  assign xfer_tid       = head.cmd[6:3];
  assign xfer_ccc       = head.cmd[14:7];
  assign xfer_ccc_en    = head.cmd[15];
  assign xfer_dev       = head.cmd[20:16];
  assign xfer_speed     = head.cmd[23:21];
  assign xfer_short     = head.cmd[27];
  assign xfer_rnw       = head.cmd[28];
  assign xfer_toc       = head.cmd[30];
  assign xfer_pec       = head.cmd[31];
  assign xfer_arg_bytes = head.arg[31:8];
  assign xfer_len       = head.cmd[27]
                        ? (16'(head.arg[3]) + 16'(head.arg[4]) + 16'(head.arg[5]))
                        : head.arg[31:16];
  assign unused_bits    = ^{head.cmd[2:0], head.cmd[25:24], head.cmd[29],
                            head.arg[7:6], head.arg[2:0], cq_full};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      halted <= 1'b0;
      busy   <= 1'b0;
      fl_roc <= 1'b0;
      fl_tid <= '0;
      fl_ccc <= '0;
    end else begin
      if (ctrl_wr) en_q <= csr_wdata[31];
      if (finish && done_err != 4'h0) halted <= 1'b1;
      else if (resume)                halted <= 1'b0;
      if (fire) begin
        busy   <= 1'b1;
        fl_roc <= head.cmd[26];
        fl_tid <= head.cmd[6:3];
        fl_ccc <= head.cmd[15] ? head.cmd[14:7] : 8'h00;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

  assign rq_push = finish && fl_roc;
  assign rq_din  = {done_err, fl_tid, fl_ccc, done_len};
  assign rq_pop  = csr_re && (csr_addr == REG_RESP);

  i3c_cmdq_fifo #(.W(32), .DEPTH(RESP_DEPTH)) u_respq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rq_push),
    .din   (rq_din),
    .pop   (rq_pop),
    .dout  (rq_dout),
    .full  (rq_full),
    .empty (rq_empty),
    .count (rq_count)
  );

  assign cq_free = CDEP - cq_count;

  always_comb begin
    case (csr_addr)
      REG_CTRL:  csr_rdata = {en_q, 31'h0};
      REG_RESP:  csr_rdata = rq_empty ? 32'h0 : rq_dout;
      REG_QSTAT: csr_rdata = {16'h0, 8'(rq_count), 8'(cq_free)};
      REG_DSTAT: csr_rdata = {8'h0, rx_level, 8'h0, tx_free};
      default:   csr_rdata = 32'h0;
    endcase
  end

  p_issue_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> en_q);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> ((xfer_valid && $stable(xfer_tid)) || !en_q));
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !xfer_valid);
  p_resp_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rq_push |-> !rq_full);
  p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && done_err != 4'h0 && !resume) |=> !xfer_valid);
endmodule

// File: tb/sim_i3c_cmdq_front.sv
module sim_i3c_cmdq_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0, csr_re = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic [7:0]  tx_free = '0, rx_level = '0;
  logic        xfer_valid, xfer_ready = 1'b0;
  logic [3:0]  xfer_tid;
  logic [7:0]  xfer_ccc;
  logic        xfer_ccc_en, xfer_rnw, xfer_short, xfer_toc, xfer_pec;
  logic [4:0]  xfer_dev;
  logic [2:0]  xfer_speed;
  logic [15:0] xfer_len;
  logic [23:0] xfer_arg_bytes;
  logic        done_valid = 1'b0;
  logic [15:0] done_len = '0;
  logic [3:0]  done_err = '0;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  i3c_cmdq_front u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic [3:0] tid, input logic [7:0] ccc,
      input logic cp, input logic [4:0] dev, input logic [2:0] spd, input logic roc,
      input logic sd, input logic rnw, input logic toc, input logic pec);
    return {pec, toc, 1'b0, rnw, sd, roc, 2'b00, spd, dev, cp, ccc, tid, 3'd0};
  endfunction

  function automatic logic [31:0] mk_arg(input logic [15:0] len, input logic [7:0] db);
    return {len, db, 5'd0, 3'd1};
  endfunction

  function automatic logic [31:0] mk_short(input logic [7:0] b2, input logic [7:0] b1,
      input logic [7:0] b0, input logic [2:0] strb);
    return {b2, b1, b0, 2'b00, strb, 3'd2};
  endfunction

  function automatic logic [24:0] fld(input logic [3:0] tid, input logic [7:0] ccc,
      input logic cp, input logic [4:0] dev, input logic [2:0] spd, input logic rnw,
      input logic sd, input logic toc, input logic pec);
    return {tid, ccc, cp, dev, spd, rnw, sd, toc, pec};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_re = 1'b1;
    #1 d = csr_rdata;
    @(negedge clk);
    csr_re = 1'b0;
  endtask

  task automatic issue(input string tag, input logic [24:0] ef,
      input logic [15:0] elen, input logic [23:0] ebytes);
    @(negedge clk);
    chk({tag, " valid"}, 64'(xfer_valid), 64'd1);
    chk({tag, " fields"}, 64'({xfer_tid, xfer_ccc, xfer_ccc_en, xfer_dev, xfer_speed,
        xfer_rnw, xfer_short, xfer_toc, xfer_pec}), 64'(ef));
    chk({tag, " len/bytes"}, 64'({xfer_len, xfer_arg_bytes}), 64'({elen, ebytes}));
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
  endtask

  task automatic fin(input logic [15:0] l, input logic [3:0] e);
    @(negedge clk);
    done_valid = 1'b1; done_len = l; done_err = e;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    rd(3'd0, r); chk("R5 reset ctrl", 64'(r), 64'h0);
    rd(3'd3, r); chk("R9 reset qstat", 64'(r), 64'h0000_0004);
    rd(3'd2, r); chk("R9 empty resp read", 64'(r), 64'h0);
    chk("R6 reset no valid", 64'(xfer_valid), 64'd0);

    // R12 data status sweep
    for (int i = 0; i < 8; i++) begin
      tx_free = 8'(i * 37); rx_level = 8'(255 - i * 11);
      rd(3'd4, r);
      chk("R12 dstat", 64'(r), 64'({8'h0, 8'(255 - i * 11), 8'h0, 8'(i * 37)}));
    end

    // R5 queued while disabled
    wr(3'd1, mk_arg(16'd3, 8'h44));
    wr(3'd1, mk_cmd(4'd9, 8'h00, 1'b0, 5'd1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    repeat (2) @(negedge clk);
    chk("R5 no issue while disabled", 64'(xfer_valid), 64'd0);
    rd(3'd3, r); chk("R5 queued free", 64'(r), 64'h0000_0003);
    wr(3'd0, 32'hC000_0000);
    rd(3'd0, r); chk("R5 ctrl readback", 64'(r), 64'h8000_0000);
    issue("R5 issue after enable", fld(4'd9, 8'h00, 1'b0, 5'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0),
          16'd3, {16'd3, 8'h44});
    fin(16'd3, 4'h0);
    rd(3'd2, r); chk("R7 resp word", 64'(r), 64'({4'h0, 4'd9, 8'h00, 16'd3}));

    // R3/R7 field sweep
    for (int i = 0; i < 16; i++) begin
      wr(3'd1, mk_arg(16'(i * 257), 8'(~i)));
      wr(3'd1, mk_cmd(4'(i), 8'(i * 17), i[0], 5'(i * 3), 3'(i), 1'b1, 1'b0,
                      i[1], i[2], i[3]));
      issue("R3 decode", fld(4'(i), 8'(i * 17), i[0], 5'(i * 3), 3'(i), i[1], 1'b0, i[2], i[3]),
            16'(i * 257), {16'(i * 257), 8'(~i)});
      fin(16'(i * 5 + 1), 4'h0);
      rd(3'd2, r);
      chk("R7 resp sweep", 64'(r),
          64'({4'h0, 4'(i), (i[0] ? 8'(i * 17) : 8'h00), 16'(i * 5 + 1)}));
    end
    rd(3'd3, r); chk("R9 qstat after sweep", 64'(r), 64'h0000_0004);

    // R2 command without argument, R7 no response when flag clear
    wr(3'd1, mk_cmd(4'd2, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    issue("R2 no-arg zero", fld(4'd2, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0),
          16'd0, 24'd0);
    fin(16'd9, 4'h0);
    rd(3'd3, r); chk("R7 no resp without flag", 64'(r), 64'h0000_0004);
    fin(16'd7, 4'h0);
    rd(3'd3, r); chk("R7 idle done ignored", 64'(r), 64'h0000_0004);

    // R2 replacement, R1 unknown kinds in between
    wr(3'd1, mk_arg(16'h0011, 8'hAA));
    wr(3'd1, mk_arg(16'h0022, 8'hBB));
    wr(3'd1, 32'hFFFF_FF05);
    wr(3'd1, 32'h1234_5677);
    wr(3'd1, mk_cmd(4'd3, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    issue("R2 R1 latest arg kept", fld(4'd3, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0),
          16'h0022, {16'h0022, 8'hBB});
    fin(16'd0, 4'h0);
    wr(3'd1, 32'hDEAD_BEE3);
    rd(3'd3, r); chk("R1 unknown not queued", 64'(r), 64'h0000_0004);
    chk("R1 unknown no issue", 64'(xfer_valid), 64'd0);

    // R4 short-data strobe sweep
    for (int s = 0; s < 8; s++) begin
      wr(3'd1, mk_short(8'(s + 16), 8'(s * 2), 8'(240 + s), 3'(s)));
      wr(3'd1, mk_cmd(4'(s), 8'h00, 1'b0, 5'd4, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
      issue("R4 short", fld(4'(s), 8'h00, 1'b0, 5'd4, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0),
            16'(s % 2 + (s / 2) % 2 + s / 4), {8'(s + 16), 8'(s * 2), 8'(240 + s)});
      fin(16'd0, 4'h0);
    end

    // R6 hold and single in flight
    wr(3'd1, mk_cmd(4'd4, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(3'd1, mk_cmd(4'd5, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    chk("R6 held while not ready", 64'({xfer_valid, xfer_tid}), 64'({1'b1, 4'd4}));
    issue("R6 first", fld(4'd4, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd0, 24'd0);
    chk("R6 none while busy", 64'(xfer_valid), 64'd0);
    repeat (3) @(negedge clk);
    chk("R6 still busy", 64'(xfer_valid), 64'd0);
    fin(16'd0, 4'h0);
    issue("R6 second in order", fld(4'd5, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0),
          16'd0, 24'd0);
    fin(16'd0, 4'h0);

    // R8 error halt and resume
    wr(3'd1, mk_cmd(4'd6, 8'h00, 1'b0, 5'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(3'd1, mk_cmd(4'd7, 8'h00, 1'b0, 5'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    issue("R8 first", fld(4'd6, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd0, 24'd0);
    fin(16'd2, 4'h3);
    rd(3'd2, r); chk("R8 error resp", 64'(r), 64'({4'h3, 4'd6, 8'h00, 16'd2}));
    repeat (2) @(negedge clk);
    chk("R8 halted", 64'(xfer_valid), 64'd0);
    wr(3'd0, 32'hC000_0000);
    rd(3'd0, r); chk("R8 resume self clears", 64'(r), 64'h8000_0000);
    issue("R8 resumed", fld(4'd7, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd0, 24'd0);
    fin(16'd1, 4'h0);
    rd(3'd2, r); chk("R8 resp after resume", 64'(r), 64'({4'h0, 4'd7, 8'h00, 16'd1}));

    // R10 overflow drop
    wr(3'd0, 32'h0);
    for (int k = 0; k < 5; k++) begin
      wr(3'd1, mk_arg(16'(8 + k), 8'h00));
      wr(3'd1, mk_cmd(4'(8 + k), 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    end
    rd(3'd3, r); chk("R10 queue full", 64'(r), 64'h0000_0000);
    wr(3'd0, 32'h8000_0000);
    for (int k = 0; k < 4; k++) begin
      issue("R10 drained", fld(4'(8 + k), 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0),
            16'(8 + k), {16'(8 + k), 8'h00});
      fin(16'd0, 4'h0);
    end
    repeat (2) @(negedge clk);
    chk("R10 fifth dropped", 64'(xfer_valid), 64'd0);

    // R11 response FIFO full stalls issue
    for (int k = 1; k <= 4; k++) begin
      wr(3'd1, mk_cmd(4'(k), 8'h00, 1'b0, 5'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
      issue("R11 fill", fld(4'(k), 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd0, 24'd0);
      fin(16'(k * 10), 4'h0);
    end
    wr(3'd1, mk_cmd(4'd5, 8'h00, 1'b0, 5'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    chk("R11 stalled on full resp", 64'(xfer_valid), 64'd0);
    rd(3'd3, r); chk("R9 R11 levels", 64'(r), 64'h0000_0403);
    rd(3'd2, r); chk("R9 resp order 1", 64'(r), 64'({4'h0, 4'd1, 8'h00, 16'd10}));
    issue("R11 issue after read", fld(4'd5, 8'h00, 1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0),
          16'd0, 24'd0);
    fin(16'd50, 4'h0);
    for (int k = 2; k <= 5; k++) begin
      rd(3'd2, r); chk("R9 resp order", 64'(r), 64'({4'h0, 4'(k), 8'h00, 16'(k * 10)}));
    end
    rd(3'd2, r); chk("R9 empty after drain", 64'(r), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule